// File: doc/BRIEF.md
# Mode-Banked CPU Register File

This block is the 32-bit general-purpose register file of a processor core that runs in several privilege modes. Each access names a 4-bit architectural register and is made in the current mode. A mapper turns the pair into one physical storage entry. Low registers are common to every mode. Some upper registers get a private copy in the fast-interrupt mode. The stack pointer and the link register each have per-mode copies, and some modes share a copy.

There are two combinational read ports and one write port that updates on the clock edge. Register 15 is the program counter and has no storage. A read of it returns the PC value that comes with the current instruction. A write to it is a branch: on the next cycle the block gives a branch pulse, an aligned target address and an updated instruction-set state flag. Instruction decode drives the ports. The status-register banks and mode changes are handled outside this block.

Top module: `mode_bank_regfile`

## Requirements
- R1: Registers 0 to 7 map to one entry shared by every mode, including an unrecognised mode encoding. A value written in any valid mode reads back in every mode.
- R2: Registers 8 to 12 have two copies each. The fast-interrupt mode (10001) uses one copy. All other valid modes share the second copy.
- R3: Register 13 has private copies for fast-interrupt (10001), interrupt (10010), supervisor (10011), abort (10111), hypervisor (11010) and undefined (11011). User (10000) and system (11111) share one copy.
- R4: Register 14 has private copies for fast-interrupt, interrupt, supervisor, abort and undefined. User, system and hypervisor share one copy.
- R5: A read of register 15 on either port returns `cur_pc_i` in the same cycle.
- R6: A write to register 15 in a valid mode raises `branch_o` for exactly the next cycle. From that cycle `tflag_o` holds bit 0 of the write data. No stored entry changes.
- R7: While `branch_o` is high, `branch_target_o` equals the write data with bit 0 cleared if `tflag_o` is 1, or with bits 1 and 0 cleared if `tflag_o` is 0.
- R8: A mode outside the eight encodings drives `mode_err_o` high in the same cycle and suppresses every write, including a write to register 15. In that mode, reads of registers 8 to 14 return zero.
- R9: A read of an entry that is being written in the same cycle returns the old value. The new value is visible from the next cycle.
- R10: Reset (active-low `rst_n`) clears every stored entry, `tflag_o` and `branch_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 5 | Current processor mode encoding |
| cur_pc_i | input | 32 | PC value of the current instruction |
| ra_idx_i | input | 4 | Read port A register index |
| ra_data_o | output | 32 | Read port A data |
| rb_idx_i | input | 4 | Read port B register index |
| rb_data_o | output | 32 | Read port B data |
| we_i | input | 1 | Write enable |
| wr_idx_i | input | 4 | Write register index |
| wr_data_i | input | 32 | Write data |
| mode_err_o | output | 1 | Mode encoding not recognised |
| branch_o | output | 1 | One-cycle branch request after a PC write |
| branch_target_o | output | 32 | Aligned branch target |
| tflag_o | output | 1 | Instruction-set state flag |

## Verification
The bench first fills every register in every mode with a value unique to that mode and register. It then reads all of them back in every mode. Shared and private copies differ only through which earlier writes survive, so this pass shows the sharing pattern of each register group. PC writes use odd and even data with both low bits set in different combinations, which separates the two alignment masks. Writes under unrecognised encodings and same-cycle read-during-write cover write suppression and the old-value read. A long stretch of random modes, indices and data then mixes all of these cases.

// File: rtl/mbrf_pkg.sv
package mbrf_pkg;
    localparam int DATA_W = 32;
    localparam int IDX_W  = 4;
    localparam int MODE_W = 5;

    localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
    localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
    localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
    localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
    localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
    localparam logic [MODE_W-1:0] MODE_HYP = 5'b11010;
    localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
    localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

    localparam int N_LOW  = 8;
    localparam int N_HIGH = 5;
    localparam int N_SP   = 7;
    localparam int N_LR   = 6;

    localparam int BASE_HIGH_SHR = N_LOW;
    localparam int BASE_HIGH_FIQ = BASE_HIGH_SHR + N_HIGH;
    localparam int BASE_SP       = BASE_HIGH_FIQ + N_HIGH;
    localparam int BASE_LR       = BASE_SP + N_SP;
    localparam int N_PHYS        = BASE_LR + N_LR;
    localparam int PHYS_W        = $clog2(N_PHYS);
    localparam int SLOT_W        = 3;

    localparam logic [IDX_W-1:0] SP_IDX = 4'd13;
    localparam logic [IDX_W-1:0] LR_IDX = 4'd14;
    localparam logic [IDX_W-1:0] PC_IDX = 4'd15;
endpackage

// File: rtl/mbrf_bank_map.sv
module mbrf_bank_map
    import mbrf_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [PHYS_W-1:0] phys_o,
    output logic              hit_o,
    output logic              pc_o,
    output logic              mode_ok_o
);
    logic              is_fiq;
    logic [SLOT_W-1:0] sp_slot;
    logic [SLOT_W-1:0] lr_slot;

    // mode decode: private slot numbers for the stack and link copies
    always_comb begin
        mode_ok_o = 1'b1;
        is_fiq    = 1'b0;
        sp_slot   = '0;
        lr_slot   = '0;
        case (mode_i)
            MODE_USR, MODE_SYS: ;
            MODE_FIQ: begin is_fiq = 1'b1; sp_slot = 3'd1; lr_slot = 3'd1; end
            MODE_IRQ: begin sp_slot = 3'd2; lr_slot = 3'd2; end
            MODE_SVC: begin sp_slot = 3'd3; lr_slot = 3'd3; end
            MODE_ABT: begin sp_slot = 3'd4; lr_slot = 3'd4; end
            MODE_HYP: begin sp_slot = 3'd5; lr_slot = 3'd0; end
            MODE_UND: begin sp_slot = 3'd6; lr_slot = 3'd5; end
            default:  mode_ok_o = 1'b0;
        endcase
    end

    // index group decode
    always_comb begin
        pc_o   = (idx_i == PC_IDX);
        hit_o  = 1'b0;
        phys_o = '0;
        if (idx_i < IDX_W'(N_LOW)) begin
            hit_o  = 1'b1;
            phys_o = PHYS_W'(idx_i);
        end else if (idx_i < SP_IDX) begin
            hit_o  = mode_ok_o;
            phys_o = PHYS_W'(is_fiq ? BASE_HIGH_FIQ : BASE_HIGH_SHR)
                   + PHYS_W'(idx_i - IDX_W'(N_LOW));
        end else if (idx_i == SP_IDX) begin
            hit_o  = mode_ok_o;
            phys_o = PHYS_W'(BASE_SP) + PHYS_W'(sp_slot);
        end else if (idx_i == LR_IDX) begin
            hit_o  = mode_ok_o;
            phys_o = PHYS_W'(BASE_LR) + PHYS_W'(lr_slot);
        end
    end
endmodule

// File: rtl/mbrf_store.sv
module mbrf_store
    import mbrf_pkg::*;
#(
    parameter int W     = DATA_W,
    parameter int DEPTH = N_PHYS,
    parameter int AW    = PHYS_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [W-1:0]  wdata_i,
    input  logic [AW-1:0] raddr_a_i,
    input  logic [AW-1:0] raddr_b_i,
    output logic [W-1:0]  rdata_a_o,
    output logic [W-1:0]  rdata_b_o
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] ent;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i && (waddr_i < AW'(DEPTH))) begin
            st_d.ent[waddr_i] = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // reads see the registered contents: old value during a write
    assign rdata_a_o = (raddr_a_i < AW'(DEPTH)) ? st_q.ent[raddr_a_i] : '0;
    assign rdata_b_o = (raddr_b_i < AW'(DEPTH)) ? st_q.ent[raddr_b_i] : '0;
endmodule

// File: rtl/mbrf_pc_unit.sv
module mbrf_pc_unit
    import mbrf_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pc_we_i,
    input  logic [W-1:0] wdata_i,
    output logic         branch_o,
    output logic [W-1:0] target_o,
    output logic         tflag_o
);
    typedef struct packed {
        logic         branch;
        logic [W-1:0] target;
        logic         tflag;
    } pc_st_t;

    pc_st_t pc_d, pc_q;

    always_comb begin
        pc_d        = pc_q;
        pc_d.branch = 1'b0;
        if (pc_we_i) begin
            pc_d.branch = 1'b1;
            pc_d.tflag  = wdata_i[0];
            pc_d.target = wdata_i[0] ? (wdata_i & ~W'(1)) : (wdata_i & ~W'(3));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    assign branch_o = pc_q.branch;
    assign target_o = pc_q.target;
    assign tflag_o  = pc_q.tflag;
endmodule

// File: rtl/mode_bank_regfile.sv
module mode_bank_regfile
    import mbrf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [DATA_W-1:0] cur_pc_i,
    input  logic [IDX_W-1:0]  ra_idx_i,
    output logic [DATA_W-1:0] ra_data_o,
    input  logic [IDX_W-1:0]  rb_idx_i,
    output logic [DATA_W-1:0] rb_data_o,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              mode_err_o,
    output logic              branch_o,
    output logic [DATA_W-1:0] branch_target_o,
    output logic              tflag_o
);
    localparam int NPORT = 3;

    logic [NPORT-1:0][IDX_W-1:0]  p_idx;
    logic [NPORT-1:0][PHYS_W-1:0] p_phys;
    logic [NPORT-1:0]             p_hit;
    logic [NPORT-1:0]             p_pc;
    logic [NPORT-1:0]             p_ok;

    assign p_idx[0] = ra_idx_i;
    assign p_idx[1] = rb_idx_i;
    assign p_idx[2] = wr_idx_i;

    for (genvar g = 0; g < NPORT; g++) begin : g_map
        mbrf_bank_map map_i (
            .mode_i   (mode_i),
            .idx_i    (p_idx[g]),
            .phys_o   (p_phys[g]),
            .hit_o    (p_hit[g]),
            .pc_o     (p_pc[g]),
            .mode_ok_o(p_ok[g])
        );
    end

    logic              st_we;
    logic              pc_we;
    logic [DATA_W-1:0] st_a, st_b;

    assign st_we      = we_i && p_ok[2] && p_hit[2];
    assign pc_we      = we_i && p_ok[2] && p_pc[2];
    assign mode_err_o = !p_ok[2];

    mbrf_store store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (st_we),
        .waddr_i  (p_phys[2]),
        .wdata_i  (wr_data_i),
        .raddr_a_i(p_phys[0]),
        .raddr_b_i(p_phys[1]),
        .rdata_a_o(st_a),
        .rdata_b_o(st_b)
    );

    mbrf_pc_unit pc_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .pc_we_i (pc_we),
        .wdata_i (wr_data_i),
        .branch_o(branch_o),
        .target_o(branch_target_o),
        .tflag_o (tflag_o)
    );

    assign ra_data_o = p_pc[0] ? cur_pc_i : (p_hit[0] ? st_a : '0);
    assign rb_data_o = p_pc[1] ? cur_pc_i : (p_hit[1] ? st_b : '0);
endmodule

// File: rtl/mbrf_checker.sv
module mbrf_checker
    import mbrf_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [MODE_W-1:0] mode_i,
    input logic [DATA_W-1:0] cur_pc_i,
    input logic [IDX_W-1:0]  ra_idx_i,
    input logic [DATA_W-1:0] ra_data_o,
    input logic [IDX_W-1:0]  rb_idx_i,
    input logic [DATA_W-1:0] rb_data_o,
    input logic              we_i,
    input logic [IDX_W-1:0]  wr_idx_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic              mode_err_o,
    input logic              branch_o,
    input logic [DATA_W-1:0] branch_target_o,
    input logic              tflag_o
);
    p_pc_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_idx_i == PC_IDX) |-> (rb_data_o == cur_pc_i));

    p_pc_branch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && wr_idx_i == PC_IDX && !mode_err_o)
        |=> (branch_o && tflag_o == $past(wr_data_i[0])));

    p_no_branch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_i && wr_idx_i == PC_IDX && !mode_err_o) |=> !branch_o);

    p_target_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
        branch_o |-> (!branch_target_o[0] && (tflag_o || !branch_target_o[1])));

    p_target_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && wr_idx_i == PC_IDX && !mode_err_o)
        |=> (branch_target_o[DATA_W-1:2] == $past(wr_data_i[DATA_W-1:2])));

    p_bad_mode_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && mode_err_o) |=> !branch_o);

    p_low_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !mode_err_o && wr_idx_i < 4'd8)
        |=> ((ra_idx_i != $past(wr_idx_i)) || (ra_data_o == $past(wr_data_i))));
endmodule

bind mode_bank_regfile mbrf_checker chk_i (.*);

// File: tb/mode_bank_regfile_tb.sv
module mode_bank_regfile_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = CLK_PERIOD / 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  mode = 5'b10000;
    logic [31:0] cur_pc = '0;
    logic [3:0]  ra_idx = '0, rb_idx = '0, wr_idx = '0;
    logic [31:0] ra_data, rb_data, wr_data = '0, tgt;
    logic        we = 1'b0;
    logic        merr, br, tfl;

    int n_tests = 0;
    int n_fail  = 0;

    logic [4:0]  codes [8] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                                5'b10111, 5'b11010, 5'b11011, 5'b11111};
    logic [31:0] mdl [8][15];
    logic        exp_br = 1'b0;
    logic        exp_t = 1'b0;
    logic [31:0] exp_tgt = '0;

    always #(HALF) clk = ~clk;

    mode_bank_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .cur_pc_i(cur_pc),
        .ra_idx_i(ra_idx), .ra_data_o(ra_data),
        .rb_idx_i(rb_idx), .rb_data_o(rb_data),
        .we_i(we), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
        .mode_err_o(merr), .branch_o(br), .branch_target_o(tgt), .tflag_o(tfl)
    );

    function automatic int midx(input logic [4:0] m);
        for (int k = 0; k < 8; k++) if (codes[k] == m) return k;
        return -1;
    endfunction

    // user=0, fiq=1, hyp=5, sys=7 in the codes list
    function automatic bit shares(input int a, input int b, input int i);
        if (i < 8)   return 1;
        if (i < 13)  return (a == 1) == (b == 1);
        if (a == b)  return 1;
        if (i == 13) return (a == 0 || a == 7) && (b == 0 || b == 7);
        return (a == 0 || a == 7 || a == 5) && (b == 0 || b == 7 || b == 5);
    endfunction

    function automatic logic [31:0] exp_read(input logic [4:0] m, input int i, input logic [31:0] pc);
        int mi = midx(m);
        if (i == 15) return pc;
        if (i < 8)   return mdl[0][i];
        if (mi < 0)  return 32'h0;
        return mdl[mi][i];
    endfunction

    function automatic string req_of(input int i);
        if (i < 8)   return "R1";
        if (i < 13)  return "R2";
        if (i == 13) return "R3";
        if (i == 14) return "R4";
        return "R5";
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input logic [4:0] m, input int ra, input int rb, input bit w,
                        input int wi, input logic [31:0] wd, input logic [31:0] pc,
                        input string req_ovr);
        int mi;
        @(negedge clk);
        mode = m; ra_idx = 4'(ra); rb_idx = 4'(rb); we = w;
        wr_idx = 4'(wi); wr_data = wd; cur_pc = pc;
        #(HALF - 1);
        mi = midx(m);
        chk(ra_data, exp_read(m, ra, pc), (req_ovr != "") ? req_ovr : req_of(ra));
        chk(rb_data, exp_read(m, rb, pc), (req_ovr != "" && rb >= 8 && rb < 15) ? req_ovr : req_of(rb));
        chk({31'b0, merr}, {31'b0, mi < 0}, "R8");
        chk({31'b0, br},  {31'b0, exp_br}, "R6");
        chk({31'b0, tfl}, {31'b0, exp_t},  "R6");
        if (exp_br) chk(tgt, exp_tgt, "R7");
        @(posedge clk);
        exp_br = 1'b0;
        if (w && mi >= 0) begin
            if (wi == 15) begin
                exp_br  = 1'b1;
                exp_t   = wd[0];
                exp_tgt = wd[0] ? (wd & ~32'd1) : (wd & ~32'd3);
            end else begin
                for (int k = 0; k < 8; k++) if (shares(mi, k, wi)) mdl[k][wi] = wd;
            end
        end
    endtask

    task automatic sweep(input string req);
        for (int k = 0; k < 8; k++)
            for (int i = 0; i < 15; i += 2)
                step(codes[k], i, (i + 1 < 15) ? i + 1 : 15, 1'b0, 0, 32'h0, 32'h1000 + 32'(i), req);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int k = 0; k < 8; k++) for (int i = 0; i < 15; i++) mdl[k][i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: all entries and PC outputs clear after reset
        sweep("R10");

        // R1..R4: unique value per mode and register, then read back everywhere
        for (int k = 0; k < 8; k++)
            for (int i = 0; i < 15; i++)
                step(codes[k], 15, 15, 1'b1, i, {8'hA0 + 8'(k), 16'h0, 8'(i)}, 32'h200, "");
        sweep("");

        // R6/R7: PC writes with different low bits
        step(5'b10011, 15, 0, 1'b1, 15, 32'h0000_1237, 32'h40, "");
        step(5'b10011, 15, 0, 1'b1, 15, 32'h8000_0FFE, 32'h44, "");
        step(5'b10000, 15, 0, 1'b1, 15, 32'h1234_5673, 32'h48, "");
        step(5'b10000, 15, 0, 1'b1, 15, 32'hFFFF_FFFC, 32'h4C, "");
        step(5'b10000, 3, 9, 1'b0, 0, 32'h0, 32'h50, "");
        sweep("R6");

        // R8: unrecognised modes, writes suppressed, banked reads zero
        step(5'b00000, 3, 9, 1'b1, 3, 32'hDEAD_0003, 32'h0, "R8");
        step(5'b10110, 13, 14, 1'b1, 13, 32'hDEAD_000D, 32'h0, "R8");
        step(5'b00000, 2, 15, 1'b1, 15, 32'hDEAD_0001, 32'h60, "R8");
        step(5'b10110, 8, 12, 1'b0, 0, 32'h0, 32'h0, "R8");
        step(5'b10000, 3, 13, 1'b0, 0, 32'h0, 32'h64, "R8");

        // R9: read during write returns old value, new value next cycle
        step(5'b10010, 13, 5, 1'b1, 13, 32'h5555_AAAA, 32'h70, "R9");
        step(5'b10010, 13, 5, 1'b1, 5, 32'h0BAD_F00D, 32'h74, "R9");
        step(5'b10001, 5, 13, 1'b0, 0, 32'h0, 32'h78, "R9");

        // mixed random traffic
        for (int n = 0; n < 600; n++) begin
            int r = $urandom_range(0, 9);
            logic [4:0] m = (r < 8) ? codes[r] : ((r == 8) ? 5'b00000 : 5'b10110);
            step(m, $urandom_range(0, 15), $urandom_range(0, 15), 1'($urandom_range(0, 1)),
                 $urandom_range(0, 15), $urandom, $urandom, "");
        end
        sweep("");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule